// File: doc/BRIEF.md
# I2C Receive Acknowledge and Clock-Stretch Controller

This block decides, for a two-wire serial bus, when the local device answers a byte with an acknowledge and when it holds the clock line low so that software can step in. It samples the data line on each rising clock edge and shifts the bits in with the most significant bit first. It checks the first byte after a START against a 7-bit local address. It drives the two lines as open-drain pull-down enables. The block works as a slave receiver and also as a master receiver. In the master role the first byte belongs to the local device, so that byte is not acknowledged here.

An address match is always acknowledged, whatever the software enable says. For data bytes, a mode input picks where the clock-stretch falls. In the 8-clock mode the wait starts after the eighth clock and the acknowledge is fixed at the moment software releases the wait. In the 9-clock mode the acknowledge is fixed at the eighth falling edge and the wait follows the ninth clock. A receiver that wants to end the transfer clears the enable. The missing acknowledge then tells the transmitter to stop before the next byte, and a STOP or repeated START can follow.

Top module: `i2c_ackwait_ctrl`

## Requirements
- R1: The first byte after a START carries seven address bits, sent MSB first on clocks 1 to 7, and the read/write bit on clock 8. That byte is compared against `own_addr_i`.
- R2: When the address matches in slave role, SDA is pulled low for clock 9, whatever the value of `ack_en_i`, and `addr_hit_o` goes high.
- R3: When the address does not match, SDA stays released on clock 9, there is no wait, and the block ignores every byte until the next START, even when `ack_en_i` is 1.
- R4: In 8-clock mode (`wait9_i` = 0), SCL is held low from the falling edge of clock 8 until a one-cycle `wait_rel_i` pulse arrives.
- R5: In 8-clock mode, a data byte is acknowledged on clock 9 only if `ack_en_i` is 1 in the cycle of the release pulse.
- R6: In 9-clock mode (`wait9_i` = 1), there is no wait after clock 8. A data byte is acknowledged if `ack_en_i` is 1 at the falling edge of clock 8, and later changes have no effect. SCL is held low from the falling edge of clock 9 until the release pulse.
- R7: When `ack_en_i` is 0, a received data byte gets no acknowledge, and SDA stays high on clock 9.
- R8: The acknowledge pull-down ends at the falling edge of clock 9.
- R9: A START while the bus is busy (a repeated START) returns bit counting to the address phase.
- R10: A STOP, and the reset state, leave both pull-downs released and `addr_hit_o` low. A release pulse outside a wait has no effect.
- R11: In master role (`master_i` = 1), the address byte is not acknowledged by the block, and the following bytes count as received data. When `xmit_i` = 1, data bytes are never acknowledged by the block.
- R12: After the falling edge of clock 8, `rx_data_o` holds the eight bits just received, with the first bit in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| own_addr_i | input | ADDR_W | Local 7-bit address |
| master_i | input | 1 | 1 when the local device addressed the bus |
| xmit_i | input | 1 | 1 when the local device sends the data bytes |
| ack_en_i | input | 1 | Software acknowledge enable for data bytes |
| wait9_i | input | 1 | 0: wait after clock 8, 1: wait after clock 9 |
| wait_rel_i | input | 1 | One-cycle pulse that ends a wait |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| addr_hit_o | output | 1 | Transfer is addressed to or owned by this device |
| rx_data_o | output | ADDR_W+1 | Last byte received |

## Verification
Every one of the 128 seven-bit addresses is sent with the acknowledge enable cleared. This separates a true compare from a partial one, and shows that the acknowledge on a match is forced; each mismatch is followed by a data byte that must stay unacknowledged. The data-byte matrix runs both wait modes against every pair of enable values: one value at the eighth falling edge and another just before the release. This tells the 8-clock release-time decision apart from the 9-clock edge-time decision. Further runs cover the master role, the transmit direction and a repeated START in the middle of a byte. Each of these would show a stuck or misaligned bit counter, or an acknowledge driven in the wrong role.

// File: rtl/i2c_ackwait_ctrl.sv
module i2c_ackwait_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              master_i,
  input  logic              xmit_i,
  input  logic              ack_en_i,
  input  logic              wait9_i,
  input  logic              wait_rel_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              addr_hit_o,
  output logic [ADDR_W:0]   rx_data_o
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_q, sda_q;
  logic active, addr_ph, wait_data;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;

  wire scl_now   = scl_s[SYNC_STAGES-1];
  wire sda_now   = sda_s[SYNC_STAGES-1];
  wire scl_rise  = scl_now & ~scl_q;
  wire scl_fall  = ~scl_now & scl_q;
  wire start_det = scl_now & scl_q & sda_q & ~sda_now;
  wire stop_det  = scl_now & scl_q & ~sda_q & sda_now;
  wire addr_eq   = shreg[BYTE_W-1:1] == own_addr_i;
  wire data_ack  = ack_en_i & ~xmit_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_q <= scl_now;
      sda_q <= sda_now;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active     <= 1'b0;
      addr_ph    <= 1'b0;
      addr_hit_o <= 1'b0;
      wait_data  <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      rx_data_o  <= '0;
      scl_low_o  <= 1'b0;
      sda_low_o  <= 1'b0;
    end else if (stop_det || start_det) begin
      active     <= start_det;
      addr_ph    <= start_det;
      addr_hit_o <= 1'b0;
      wait_data  <= 1'b0;
      cnt        <= '0;
      scl_low_o  <= 1'b0;
      sda_low_o  <= 1'b0;
    end else begin
      if (scl_low_o && wait_rel_i) begin
        scl_low_o <= 1'b0;
        wait_data <= 1'b0;
        if (wait_data) sda_low_o <= data_ack;
      end
      if (active && scl_rise) begin
        shreg <= {shreg[BYTE_W-2:0], sda_now};
        cnt   <= cnt + 1'b1;
      end
      if (active && scl_fall) begin
        if (cnt == LAST_BIT) begin
          rx_data_o <= shreg;
          if (addr_ph) begin
            if (master_i || addr_eq) begin
              addr_hit_o <= 1'b1;
              sda_low_o  <= ~master_i;
              if (!wait9_i) scl_low_o <= 1'b1;
            end else begin
              active <= 1'b0;
            end
          end else if (addr_hit_o) begin
            if (wait9_i) sda_low_o <= data_ack;
            else begin
              scl_low_o <= 1'b1;
              wait_data <= 1'b1;
            end
          end
        end else if (cnt == ACK_BIT) begin
          sda_low_o <= 1'b0;
          cnt       <= '0;
          addr_ph   <= 1'b0;
          if (wait9_i && addr_hit_o) scl_low_o <= 1'b1;
        end
      end
    end

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!scl_low_o && !sda_low_o)); // R10
  AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> (cnt == LAST_BIT || cnt == ACK_BIT)); // R8
  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low_o && !wait_rel_i && !start_det && !stop_det) |=> scl_low_o); // R4
  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low_o && wait_rel_i) |=> !scl_low_o); // R4
  AST_ADDR_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low_o) && addr_ph) |-> (rx_data_o[BYTE_W-1:1] == own_addr_i)); // R2
  AST_NO_ACK_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low_o) && !addr_ph) |-> !xmit_i); // R11

endmodule

// File: tb/i2c_ackwait_ctrl_tb.sv
module i2c_ackwait_ctrl_tb_top;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic master_i = 1'b0, xmit_i = 1'b0, ack_en_i = 1'b0, wait9_i = 1'b1, wait_rel_i = 1'b0;
  logic scl_low_o, sda_low_o, addr_hit_o;
  logic [7:0] rx_data_o;
  int errors = 0, checks = 0;
  bit reported = 0;

  wire scl_bus = m_scl & ~scl_low_o;
  wire sda_bus = ~(m_sda_low | sda_low_o);

  always #2.5 clk = ~clk;

  i2c_ackwait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .own_addr_i(OWN),
    .master_i(master_i), .xmit_i(xmit_i), .ack_en_i(ack_en_i), .wait9_i(wait9_i),
    .wait_rel_i(wait_rel_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .addr_hit_o(addr_hit_o), .rx_data_o(rx_data_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
    wclk(H);
  endtask

  task automatic do_start();
    m_sda_low = 1'b0; wclk(H);
    scl_up();
    m_sda_low = 1'b1; wclk(H);
    m_scl = 1'b0; wclk(H);
  endtask

  task automatic do_stop();
    m_sda_low = 1'b1; wclk(H);
    scl_up();
    m_sda_low = 1'b0; wclk(H);
  endtask

  task automatic clock_bit(bit b);
    m_sda_low = ~b; wclk(H);
    scl_up();
    m_scl = 1'b0; wclk(H);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
  endtask

  task automatic ack_clock(output bit acked);
    m_sda_low = 1'b0; wclk(H);
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
    wclk(H / 2);
    acked = ~sda_bus;
    wclk(H / 2);
    m_scl = 1'b0; wclk(H);
  endtask

  task automatic release_wait(string tag);
    wclk(20);
    chk(tag, scl_low_o, 1);
    wait_rel_i = 1'b1; @(negedge clk); wait_rel_i = 1'b0;
    wclk(2);
    chk(tag, scl_low_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    bit a;
    int k;
    logic [7:0] d;
    wclk(4);
    chk("R10 reset scl", scl_low_o, 0);
    chk("R10 reset sda", sda_low_o, 0);
    chk("R10 reset hit", addr_hit_o, 0);
    rst_n = 1'b1;
    wclk(4);

    wait_rel_i = 1'b1; @(negedge clk); wait_rel_i = 1'b0; wclk(2);
    chk("R10 idle release", scl_low_o, 0);

    // R1 R2 R3: every address, enable cleared, 9-clock mode
    wait9_i = 1'b1; ack_en_i = 1'b0;
    for (int ad = 0; ad < 128; ad++) begin
      d = {ad[6:0], ad[0]};
      do_start();
      send_byte(d);
      chk("R12 addr byte", rx_data_o, d);
      ack_clock(a);
      chk("R2/R1 addr ack", a, (ad == OWN) ? 1 : 0);
      chk("R3 addr hit", addr_hit_o, (ad == OWN) ? 1 : 0);
      if (ad == OWN) release_wait("R6 addr wait");
      else begin
        chk("R3 no wait", scl_low_o, 0);
        ack_en_i = 1'b1;
        send_byte(8'h5A);
        ack_clock(a);
        chk("R3 ignored data", a, 0);
        chk("R3 no wait data", scl_low_o, 0);
        ack_en_i = 1'b0;
      end
      do_stop();
      chk("R10 stop lines", scl_low_o + sda_low_o, 0);
      chk("R10 stop hit", addr_hit_o, 0);
    end

    // R4 R5 R6 R7 R8: mode by enable matrix
    k = 0;
    for (int m = 0; m < 2; m++)
      for (int e0 = 0; e0 < 2; e0++)
        for (int e1 = 0; e1 < 2; e1++) begin
          wait9_i = m[0]; ack_en_i = 1'b1;
          do_start();
          send_byte({OWN, 1'b0});
          if (m == 0) release_wait("R4 addr wait");
          ack_clock(a);
          chk("R2 addr ack", a, 1);
          if (m == 1) release_wait("R6 addr wait");
          d = 8'h3C ^ 8'(k * 37); k++;
          ack_en_i = e0[0];
          send_byte(d);
          chk("R12 data byte", rx_data_o, d);
          ack_en_i = e1[0];
          if (m == 0) release_wait("R4 data wait");
          else chk("R6 no wait at 8", scl_low_o, 0);
          ack_clock(a);
          if (m == 0) chk("R5 ack at release", a, e1);
          else chk("R6 ack at clock 8", a, e0);
          if ((m == 0 && e1 == 0) || (m == 1 && e0 == 0)) chk("R7 nack", a, 0);
          chk("R8 sda released", sda_low_o, 0);
          if (m == 1) release_wait("R6 data wait");
          do_stop();
        end

    // R11: master receiver
    master_i = 1'b1; wait9_i = 1'b1; ack_en_i = 1'b1;
    do_start();
    send_byte({7'h13, 1'b1});
    ack_clock(a);
    chk("R11 master addr no ack", a, 0);
    chk("R11 master hit", addr_hit_o, 1);
    release_wait("R11 master wait");
    send_byte(8'hC3);
    ack_clock(a);
    chk("R11 master data ack", a, 1);
    release_wait("R11 master wait2");
    ack_en_i = 1'b0;
    send_byte(8'h81);
    ack_clock(a);
    chk("R7 master end nack", a, 0);
    release_wait("R11 master wait3");
    do_stop();
    master_i = 1'b0;

    // R11: transmit direction
    ack_en_i = 1'b1;
    do_start();
    send_byte({OWN, 1'b1});
    ack_clock(a);
    chk("R2 addr ack read", a, 1);
    release_wait("R6 addr wait read");
    xmit_i = 1'b1;
    send_byte(8'h96);
    ack_clock(a);
    chk("R11 xmit no ack", a, 0);
    release_wait("R11 xmit wait");
    do_stop();
    xmit_i = 1'b0;

    // R9: repeated start mid byte
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(a);
    release_wait("R9 first wait");
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
    do_start();
    send_byte({OWN, 1'b1});
    chk("R9 realigned byte", rx_data_o, {OWN, 1'b1});
    ack_clock(a);
    chk("R9 ack after restart", a, 1);
    release_wait("R9 second wait");
    do_stop();

    wclk(4);
    report();
  end
endmodule